// File: doc/BRIEF.md
# Packed-Pixel Virtual Memory Window

This block gives a coprocessor a view of a byte-wide backing RAM as one flat array of small elements, each 2 or 4 bits wide. The coprocessor reaches it through a fixed range of 32 banks, $60 to $7F, in its 24-bit address space. Every access in that range becomes a RAM byte address plus a field select. A read returns the selected field, zero-extended, in the low bits of the data bus. A write reads the RAM byte, replaces only the selected field and writes the byte back. The bus reports not-ready until the access has finished.

A one-bit mode register picks the element width. The mode is captured when an access is accepted, so every access uses the width that was set when it began. Addresses outside the window are not handled here: the block answers them at once and starts no RAM cycle. Packed 2bpp and 4bpp pixel buffers can then be addressed one pixel per address.

Top module: `packed_pixel_window`

## Requirements
- R1: An access whose bank lies outside $60..$7F is answered ready in the same cycle, with read data 0, and starts no RAM read or write.
- R2: In 4-bit mode, window offset N (address minus $600000) maps to RAM byte N>>1. Offset bit 0 equal to 0 selects bits 3:0 and equal to 1 selects bits 7:4.
- R3: In 2-bit mode, offset N maps to RAM byte N>>2. Offset bits 1:0 equal to k select bits 2k+1:2k.
- R4: Read data carries the selected element in its low bits, and every bit above the element width is 0.
- R5: A write changes only the selected field of the RAM byte, loading it with the low bits of the write data. All other bits of that byte, and all other bytes, keep their values.
- R6: Banks $60..$7F form one contiguous element array: offset $0FFFFF is followed by offset $100000. The RAM byte index is the low RAM_AW bits of the computed index.
- R7: A window read is answered ready 3 cycles after it is accepted, and a window write 4 cycles after. The write-back happens two cycles after the RAM read of the same byte.
- R8: cfg_we_i loads cfg_mode4_i into the mode register (1 = 4-bit, 0 = 2-bit). After reset the mode is 2-bit.
- R9: After reset, cp_ready_o is 1 and neither RAM strobe is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Load the mode register |
| cfg_mode4_i | input | 1 | Mode value: 1 = 4-bit elements, 0 = 2-bit elements |
| cp_addr_i | input | 24 | Coprocessor address |
| cp_rd_i | input | 1 | Read strobe, held until ready |
| cp_wr_i | input | 1 | Write strobe, held until ready |
| cp_wdata_i | input | 8 | Write data; only the low bits of the element width are used |
| cp_rdata_o | output | 8 | Read data, zero-extended element |
| cp_ready_o | output | 1 | Access complete |
| ram_addr_o | output | RAM_AW | Backing RAM byte address |
| ram_rd_o | output | 1 | RAM read strobe; data is returned on the next cycle |
| ram_wr_o | output | 1 | RAM write strobe |
| ram_wdata_o | output | 8 | RAM write data |
| ram_rdata_i | input | 8 | RAM read data |

## Verification
The RAM is preloaded with a pattern in which every byte differs. Full sweeps of window offsets are run in both modes, so that each field of each byte is read once. A wrong shift, a swapped field order or a wrong byte index would show up as a mismatch. The sweeps are repeated after writes whose data carries junk in its upper bits, which separates a correct merge from one that spills into neighbouring fields. Addresses at the bank seams $6F/$70 and at both window edges separate a correct window decode from an off-by-one bank limit.

// File: rtl/ppw_pkg.sv
package ppw_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_FETCH,
    S_WAIT,
    S_WBACK,
    S_DONE
  } seq_state_e;
endpackage

// File: rtl/ppw_addr_map.sv
module ppw_addr_map #(
  parameter int ADDR_W    = 24,
  parameter int RAM_AW    = 18,
  parameter int WIN_BANK  = 'h60,
  parameter int WIN_BANKS = 32
) (
  input  logic              mode4_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o,
  output logic [RAM_AW-1:0] byte_addr_o,
  output logic [1:0]        sel_o
);
  localparam int BANK_W = ADDR_W - 16;
  localparam int OFF_W  = 16 + $clog2(WIN_BANKS);
  localparam logic [BANK_W:0] BANK_LO = (BANK_W+1)'(WIN_BANK);
  localparam logic [BANK_W:0] BANK_HI = (BANK_W+1)'(WIN_BANK + WIN_BANKS);
  localparam logic [OFF_W-1:0] BASE_LO = OFF_W'(WIN_BANK * 65536);

  logic [BANK_W:0]  bank;
  logic [OFF_W-1:0] off;
  logic [OFF_W-1:0] byte_full;

  assign bank  = {1'b0, addr_i[ADDR_W-1:16]};
  assign hit_o = (bank >= BANK_LO) && (bank < BANK_HI);
  // window is bank-aligned, so the offset is a low-bit subtraction
  assign off       = addr_i[OFF_W-1:0] - BASE_LO;
  assign byte_full = mode4_i ? (off >> 1) : (off >> 2);
  assign sel_o     = off[1:0];

  generate
    if (RAM_AW <= OFF_W) begin : g_trunc
      assign byte_addr_o = byte_full[RAM_AW-1:0];
      if (RAM_AW < OFF_W) begin : g_drop
        logic unused_hi;
        assign unused_hi = ^byte_full[OFF_W-1:RAM_AW];
      end
    end else begin : g_ext
      assign byte_addr_o = {{(RAM_AW-OFF_W){1'b0}}, byte_full};
    end
  endgenerate
endmodule

// File: rtl/ppw_field_lane.sv
module ppw_field_lane #(
  parameter int DATA_W = 8
) (
  input  logic              mode4_i,
  input  logic [1:0]        sel_i,
  input  logic [DATA_W-1:0] byte_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] elem_o,
  output logic [DATA_W-1:0] merged_o,
  output logic [DATA_W-1:0] mask_o
);
  localparam int SH_W = $clog2(DATA_W);

  logic [SH_W-1:0]   shift;
  logic [DATA_W-1:0] base_mask;

  assign shift     = mode4_i ? SH_W'({sel_i[0], 2'b00}) : SH_W'({sel_i, 1'b0});
  assign base_mask = mode4_i ? DATA_W'(4'hF) : DATA_W'(2'h3);
  assign mask_o    = base_mask << shift;
  assign elem_o    = (byte_i & mask_o) >> shift;
  assign merged_o  = (byte_i & ~mask_o) | ((wdata_i << shift) & mask_o);
endmodule

// File: rtl/ppw_seq.sv
module ppw_seq
  import ppw_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic wr_i,
  output logic accept_o,
  output logic ram_rd_o,
  output logic cap_o,
  output logic ram_wr_o,
  output logic done_o,
  output logic idle_o,
  output logic wr_q_o
);
  seq_state_e state_q, state_d;
  logic       wr_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE:  if (req_i) state_d = S_FETCH;
      S_FETCH: state_d = S_WAIT;
      S_WAIT:  state_d = wr_q ? S_WBACK : S_DONE;
      S_WBACK: state_d = S_DONE;
      S_DONE:  state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      wr_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept_o) wr_q <= wr_i;
    end
  end

  assign idle_o   = (state_q == S_IDLE);
  assign accept_o = idle_o && req_i;
  assign ram_rd_o = (state_q == S_FETCH);
  assign cap_o    = (state_q == S_WAIT);
  assign ram_wr_o = (state_q == S_WBACK);
  assign done_o   = (state_q == S_DONE);
  assign wr_q_o   = wr_q;

  // R7: one RAM read per access
  a_r7_rd_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_rd_o |=> !ram_rd_o);
  // R7: write-back only for accepted writes
  a_r7_wb_only_wr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_wr_o |-> wr_q);
endmodule

// File: rtl/packed_pixel_window.sv
module packed_pixel_window #(
  parameter int ADDR_W    = 24,
  parameter int DATA_W    = 8,
  parameter int RAM_AW    = 18,
  parameter int WIN_BANK  = 'h60,
  parameter int WIN_BANKS = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic              cfg_mode4_i,
  input  logic [ADDR_W-1:0] cp_addr_i,
  input  logic              cp_rd_i,
  input  logic              cp_wr_i,
  input  logic [DATA_W-1:0] cp_wdata_i,
  output logic [DATA_W-1:0] cp_rdata_o,
  output logic              cp_ready_o,
  output logic [RAM_AW-1:0] ram_addr_o,
  output logic              ram_rd_o,
  output logic              ram_wr_o,
  output logic [DATA_W-1:0] ram_wdata_o,
  input  logic [DATA_W-1:0] ram_rdata_i
);
  logic              mode_q, mode_l_q;
  logic              hit, req, accept, cap, done, idle, wr_q;
  logic [RAM_AW-1:0] byte_addr, addr_q;
  logic [1:0]        sel, sel_q;
  logic [DATA_W-1:0] wdata_q, rdata_q, wbyte_q;
  logic [DATA_W-1:0] elem, merged, mask;
  logic [2:0]        busy_cnt;

  ppw_addr_map #(
    .ADDR_W(ADDR_W), .RAM_AW(RAM_AW), .WIN_BANK(WIN_BANK), .WIN_BANKS(WIN_BANKS)
  ) u_map (
    .mode4_i(mode_q), .addr_i(cp_addr_i), .hit_o(hit),
    .byte_addr_o(byte_addr), .sel_o(sel)
  );

  ppw_field_lane #(.DATA_W(DATA_W)) u_lane (
    .mode4_i(mode_l_q), .sel_i(sel_q), .byte_i(ram_rdata_i), .wdata_i(wdata_q),
    .elem_o(elem), .merged_o(merged), .mask_o(mask)
  );

  assign req = hit && (cp_rd_i || cp_wr_i);

  ppw_seq u_seq (
    .clk_i, .rst_ni, .req_i(req), .wr_i(cp_wr_i), .accept_o(accept),
    .ram_rd_o, .cap_o(cap), .ram_wr_o, .done_o(done), .idle_o(idle), .wr_q_o(wr_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q   <= 1'b0;
      mode_l_q <= 1'b0;
      addr_q   <= '0;
      sel_q    <= '0;
      wdata_q  <= '0;
      rdata_q  <= '0;
      wbyte_q  <= '0;
    end else begin
      if (cfg_we_i) mode_q <= cfg_mode4_i;
      if (accept) begin
        mode_l_q <= mode_q;
        addr_q   <= byte_addr;
        sel_q    <= sel;
        wdata_q  <= cp_wdata_i;
      end
      if (cap && !wr_q) rdata_q <= elem;
      if (cap && wr_q)  wbyte_q <= merged;
    end
  end

  assign ram_addr_o  = addr_q;
  assign ram_wdata_o = wbyte_q;
  assign cp_ready_o  = done || (idle && !req);
  assign cp_rdata_o  = done ? rdata_q : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         busy_cnt <= '0;
    else if (cp_ready_o) busy_cnt <= '0;
    else if (busy_cnt != 3'd7) busy_cnt <= busy_cnt + 3'd1;
  end

  // R1: a miss never starts a RAM cycle
  a_r1_no_ram_on_miss: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle && (cp_rd_i || cp_wr_i) && !hit) |=> !ram_rd_o);
  // R4: bits above a 2-bit element stay zero
  a_r4_zero_ext: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done && !mode_l_q) |-> (cp_rdata_o[DATA_W-1:2] == '0));
  // R5: write-back only differs from the fetched byte inside the field
  a_r5_keep_other_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_wr_o |-> (((ram_wdata_o ^ $past(ram_rdata_i)) & ~mask) == '0));
  // R7: write-back two cycles after the fetch
  a_r7_wb_after_fetch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_wr_o |-> $past(ram_rd_o, 2));
  // R7: bus never stalls more than four cycles
  a_r7_busy_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cp_ready_o |-> (busy_cnt <= 3'd3));
endmodule

// File: tb/packed_pixel_window_tb.sv
module packed_pixel_window_tb;
  localparam int AW = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0, cfg_mode4 = 1'b0;
  logic [23:0] cp_addr = '0;
  logic cp_rd = 1'b0, cp_wr = 1'b0;
  logic [7:0] cp_wdata = '0, cp_rdata, ram_wdata, ram_rdata;
  logic cp_ready, ram_rd, ram_wr;
  logic [AW-1:0] ram_addr;

  logic [7:0] mem [256];
  logic [7:0] exp_mem [256];
  int ram_rd_cnt = 0, ram_wr_cnt = 0;
  int checks = 0, errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  packed_pixel_window #(.RAM_AW(AW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_mode4_i(cfg_mode4),
    .cp_addr_i(cp_addr), .cp_rd_i(cp_rd), .cp_wr_i(cp_wr), .cp_wdata_i(cp_wdata),
    .cp_rdata_o(cp_rdata), .cp_ready_o(cp_ready), .ram_addr_o(ram_addr),
    .ram_rd_o(ram_rd), .ram_wr_o(ram_wr), .ram_wdata_o(ram_wdata), .ram_rdata_i(ram_rdata)
  );

  function automatic logic [7:0] pattern(int i);
    return 8'((i * 37) ^ 'h5A);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= pattern(i);
      ram_rdata <= '0;
    end else begin
      if (ram_rd) begin ram_rdata <= mem[ram_addr]; ram_rd_cnt <= ram_rd_cnt + 1; end
      if (ram_wr) begin mem[ram_addr] <= ram_wdata; ram_wr_cnt <= ram_wr_cnt + 1; end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic int byte_of(input bit m4, input logic [23:0] a);
    logic [23:0] off = a - 24'h600000;
    return int'(m4 ? ((off >> 1) & 24'hFF) : ((off >> 2) & 24'hFF));
  endfunction

  function automatic int field_shift(input bit m4, input logic [23:0] a);
    logic [23:0] off = a - 24'h600000;
    return m4 ? 4 * int'(off[0]) : 2 * int'(off[1:0]);
  endfunction

  function automatic logic [7:0] exp_elem(input bit m4, input logic [23:0] a);
    logic [7:0] b = exp_mem[byte_of(m4, a)];
    return (b >> field_shift(m4, a)) & (m4 ? 8'h0F : 8'h03);
  endfunction

  task automatic access(input bit wr, input logic [23:0] a, input logic [7:0] wd,
                        output logic [7:0] rd, output int cyc);
    @(negedge clk);
    cp_addr = a; cp_wdata = wd; cp_rd = !wr; cp_wr = wr;
    cyc = 0;
    #1;
    while (!cp_ready && cyc < 50) begin @(negedge clk); cyc++; end
    rd = cp_rdata;
    cp_rd = 1'b0; cp_wr = 1'b0;
  endtask

  task automatic set_mode(input bit m4);
    @(negedge clk); cfg_we = 1'b1; cfg_mode4 = m4;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic rd_check(input bit m4, input logic [23:0] a, input string tag);
    logic [7:0] rd; int cyc;
    access(1'b0, a, 8'h00, rd, cyc);
    chk(rd == exp_elem(m4, a), tag, rd, exp_elem(m4, a));
  endtask

  task automatic wr_check(input bit m4, input logic [23:0] a, input logic [7:0] wd);
    logic [7:0] rd, msk, nb; int cyc, b, sh;
    b = byte_of(m4, a); sh = field_shift(m4, a);
    msk = (m4 ? 8'h0F : 8'h03) << sh;
    nb = (exp_mem[b] & ~msk) | ((wd << sh) & msk);
    exp_mem[b] = nb;
    access(1'b1, a, wd, rd, cyc);
    @(negedge clk);
    chk(mem[b] == nb, "R5 merged byte", mem[b], nb);
  endtask

  task automatic full_mem_check(input string tag);
    for (int i = 0; i < 256; i++) chk(mem[i] == exp_mem[i], tag, mem[i], exp_mem[i]);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    logic [7:0] rd; int cyc, rc, wc;
    for (int i = 0; i < 256; i++) exp_mem[i] = pattern(i);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cp_ready == 1'b1, "R9 ready after reset", cp_ready, 1);
    chk(ram_rd == 1'b0 && ram_wr == 1'b0, "R9 RAM strobes idle", {ram_rd, ram_wr}, 0);

    // R8: reset mode is 2-bit
    rd_check(1'b0, 24'h600005, "R8 reset mode 2-bit");

    // R3/R4: 2-bit sweep covering all bytes and pairs
    for (int n = 0; n < 1024; n++) rd_check(1'b0, 24'h600000 + 24'(n), "R3 2-bit read");

    set_mode(1'b1);
    // R2/R4: 4-bit sweep
    for (int n = 0; n < 512; n++) rd_check(1'b1, 24'h600000 + 24'(n), "R2 4-bit read");

    // R6: bank seams and window edges
    rd_check(1'b1, 24'h6FFFFF, "R6 last of bank 6F");
    rd_check(1'b1, 24'h700000, "R6 first of bank 70");
    rd_check(1'b1, 24'h7FFFFF, "R6 last of window");
    rd_check(1'b1, 24'h712345, "R6 upper half");

    // R7: latency
    access(1'b0, 24'h600010, 8'h00, rd, cyc);
    chk(cyc == 3, "R7 read latency", cyc, 3);
    rd = exp_elem(1'b1, 24'h600010);
    access(1'b1, 24'h600010, rd, rd, cyc);
    chk(cyc == 4, "R7 write latency", cyc, 4);

    // R1: misses
    rc = ram_rd_cnt; wc = ram_wr_cnt;
    access(1'b0, 24'h5FFFFF, 8'h00, rd, cyc);
    chk(cyc == 0 && rd == 8'h00, "R1 miss read below", {cyc[7:0], rd}, 0);
    access(1'b1, 24'h800000, 8'hFF, rd, cyc);
    chk(cyc == 0, "R1 miss write above", cyc, 0);
    access(1'b1, 24'h400123, 8'hFF, rd, cyc);
    chk(cyc == 0, "R1 miss write low bank", cyc, 0);
    repeat (3) @(negedge clk);
    chk(ram_rd_cnt == rc && ram_wr_cnt == wc, "R1 no RAM cycle", ram_rd_cnt - rc + ram_wr_cnt - wc, 0);
    full_mem_check("R1 memory untouched");

    // R5: 4-bit writes with junk in upper data bits
    for (int n = 0; n < 64; n++) wr_check(1'b1, 24'h600000 + 24'(n), 8'(n * 7 + 'hA3));
    wr_check(1'b1, 24'h700001, 8'hF6);
    full_mem_check("R5 4-bit neighbours kept");
    set_mode(1'b0);
    for (int n = 0; n < 128; n++) wr_check(1'b0, 24'h600000 + 24'(n), 8'(n ^ 'hA5));
    full_mem_check("R5 2-bit neighbours kept");
    for (int n = 0; n < 1024; n++) rd_check(1'b0, 24'h600000 + 24'(n), "R4 2-bit readback");

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule